// File: doc/BRIEF.md
# Programmable-Rate Countdown Timer

This block is an 8-bit down-counter for a low-power clock domain. It steps down by one on single-cycle tick strobes. The strobes come from taps of a prescaler that divides a 32.768 kHz time base, and a control field picks which tap drives the counter. When the count steps from one to zero, the block raises a one-cycle zero-reached event. After that it either stays at zero or, if auto-reload is on, copies a stored reload value back into the counter on the next selected tick and keeps counting.

Software reaches the block through a small synchronous write port with two addresses. Address 0 is the control register. Address 1 is the count register, and a write there sets both the live count and the reload value. After reset the timer is disabled and the rate is 32 Hz. That 32 Hz rate is a reset-only choice: it stays in force until software performs a control write that also requests a rate update. The live count is always visible on an output. Routing the zero event to an interrupt pin is left to the surrounding logic.

Top module: `cdt_top`

## Requirements
- R1: After reset, the count and the reload value are 0, the timer is disabled, auto-reload is off, the 32 Hz tap (tick_taps bit 4) is selected, and zero_evt_o is low.
- R2: A write to address 0 loads the control register. Bit 0 enables the timer and bit 1 enables auto-reload. When bit 4 is 1, bits 3:2 (TD) are loaded and the 32 Hz reset selection is dropped. When bit 4 is 0, the current rate is kept.
- R3: TD values 0, 1, 2 and 3 select tick_taps bits 0 (4096 Hz), 1 (64 Hz), 2 (1 Hz) and 3 (1/60 Hz). Strobes on taps that are not selected have no effect.
- R4: A write to address 1 loads wr_data into both the count and the reload value. A tick in the same cycle is ignored.
- R5: While the timer is disabled, tick strobes leave the count unchanged.
- R6: While enabled, each selected tick lowers a nonzero count by exactly one, visible one clock after the strobe.
- R7: zero_evt_o is high for exactly one cycle. That cycle is the first one in which the count shows 0 after a tick took it from 1 to 0.
- R8: With auto-reload off, a count of 0 stays at 0 on later ticks, and no further zero event occurs until the count is rewritten.
- R9: With auto-reload on, a selected tick while the count is 0 loads the reload value, and counting continues from there.
- R10: Loading the count with 0 through address 1 does not produce a zero event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_taps | input | 5 | Prescaler strobes: 4096 Hz, 64 Hz, 1 Hz, 1/60 Hz, 32 Hz (bits 0..4) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control, 1 = count |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current count |
| zero_evt_o | output | 1 | One-cycle zero-reached event |

## Verification
The bench builds the block with its default 8-bit count width, which fixes the five-tap arrangement. The bench drives the prescaler taps directly as strobes rather than dividing a real 32.768 kHz clock, so a full reload period or a run from 255 down to zero takes only a few hundred clock cycles. Each of the four TD rates and the 32 Hz reset default can therefore be checked against every other tap. A behavioural model is compared with the count and the zero event on every clock. A randomized phase mixes writes, rate changes and taps.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int RATE_N      = 4;
    localparam int TAP_N       = RATE_N + 1;
    localparam int TAP_DEF_IDX = RATE_N;
    localparam int IDX_W       = $clog2(TAP_N);
    localparam int CTRL_W      = 5;

    typedef enum logic [1:0] {
        RATE_4K  = 2'd0,
        RATE_64  = 2'd1,
        RATE_1   = 2'd2,
        RATE_MIN = 2'd3
    } rate_e;

    typedef enum logic {
        ADDR_CTRL  = 1'b0,
        ADDR_COUNT = 1'b1
    } addr_e;

    typedef struct packed {
        logic  use_default;
        rate_e rate;
        logic  reload_en;
        logic  en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_DEC,
        ACT_RELOAD
    } act_e;

    localparam ctrl_t CTRL_RESET = '{use_default: 1'b1, rate: RATE_4K,
                                     reload_en: 1'b0, en: 1'b0};

    function automatic logic [IDX_W-1:0] tap_index(input ctrl_t c);
        if (c.use_default)
            return IDX_W'(TAP_DEF_IDX);
        return IDX_W'(c.rate);
    endfunction

    function automatic ctrl_t ctrl_update(input ctrl_t cur,
                                          input logic [CTRL_W-1:0] wd);
        ctrl_t n;
        n           = cur;
        n.en        = wd[0];
        n.reload_en = wd[1];
        if (wd[4]) begin
            n.rate        = rate_e'(wd[3:2]);
            n.use_default = 1'b0;
        end
        return n;
    endfunction

endpackage

// File: rtl/cdt_ctrl_regs.sv
module cdt_ctrl_regs
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output ctrl_t             ctrl_q,
    output logic              load_stb
);

    logic ctrl_wr;

    assign ctrl_wr  = wr_en && (addr_e'(wr_addr) == ADDR_CTRL);
    assign load_stb = wr_en && (addr_e'(wr_addr) == ADDR_COUNT);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RESET;
        else if (ctrl_wr)
            ctrl_q <= ctrl_update(ctrl_q, ctrl_wdata);
    end

    // R2: a rate-update write drops the 32 Hz reset selection
    p_rate_override_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_wdata[4]) |=> !ctrl_q.use_default);

    // R2: without the update bit the rate field is kept
    p_rate_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_wdata[4]) |=> ($stable(ctrl_q.rate) && $stable(ctrl_q.use_default)));

endmodule

// File: rtl/cdt_tick_sel.sv
module cdt_tick_sel
    import cdt_pkg::*;
(
    input  logic [TAP_N-1:0] taps,
    input  logic [IDX_W-1:0] idx,
    output logic             tick
);

    logic [TAP_N-1:0] hit;

    for (genvar i = 0; i < TAP_N; i++) begin : g_tap
        assign hit[i] = taps[i] && (idx == IDX_W'(i));
    end

    assign tick = |hit;

    always_comb begin
        p_single_tap_r3: assert ($onehot0(hit));
    end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             reload_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             zero_evt
);

    import cdt_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rld_q;
    act_e             act;

    always_comb begin
        act = ACT_HOLD;
        if (load_stb)
            act = ACT_LOAD;
        else if (tick && en)
            act = (cnt_q != '0) ? ACT_DEC : (reload_en ? ACT_RELOAD : ACT_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            rld_q    <= '0;
            zero_evt <= 1'b0;
        end else begin
            zero_evt <= 1'b0;
            unique case (act)
                ACT_LOAD: begin
                    cnt_q <= load_val;
                    rld_q <= load_val;
                end
                ACT_DEC: begin
                    cnt_q    <= cnt_q - ONE;
                    zero_evt <= (cnt_q == ONE);
                end
                ACT_RELOAD: cnt_q <= rld_q;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    // R4: a count write loads the value regardless of ticks
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> (cnt_q == $past(load_val)));

    // R5: disabled timer holds
    p_hold_off_r5: assert property (@(posedge clk) disable iff (rst)
        (!en && !load_stb) |=> $stable(cnt_q));

    // R6: single step per tick
    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && en && !load_stb && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    // R7: the event coincides with a zero count and lasts one cycle
    p_evt_zero_r7: assert property (@(posedge clk) disable iff (rst)
        zero_evt |-> (cnt_q == '0));
    p_evt_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        zero_evt |=> !zero_evt);

    // R8: no reload means zero is sticky
    p_stay_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !reload_en && !load_stb) |=> (cnt_q == '0 && !zero_evt));

    // R9: reload on a tick at zero
    p_reload_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && en && reload_en && !load_stb && cnt_q == '0) |=> (cnt_q == $past(rld_q)));

    // R10: writes never raise the event
    p_no_evt_load_r10: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !zero_evt);

endmodule

// File: rtl/cdt_top.sv
module cdt_top
    import cdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       tick_taps,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_evt_o
);

    ctrl_t            ctrl_q;
    logic             load_stb;
    logic             tick;
    logic [IDX_W-1:0] sel_idx;

    assign sel_idx = tap_index(ctrl_q);

    cdt_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .ctrl_wdata (wr_data[CTRL_W-1:0]),
        .ctrl_q     (ctrl_q),
        .load_stb   (load_stb)
    );

    cdt_tick_sel u_sel (
        .taps (tick_taps),
        .idx  (sel_idx),
        .tick (tick)
    );

    cdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .en        (ctrl_q.en),
        .reload_en (ctrl_q.reload_en),
        .load_stb  (load_stb),
        .load_val  (wr_data),
        .cnt_q     (count_o),
        .zero_evt  (zero_evt_o)
    );

    // R1: reset state seen at the ports
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !zero_evt_o));

endmodule

// File: tb/sim_cdt_top.sv
`timescale 1ns/1ps
module sim_cdt_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] tick_taps = '0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] count_o;
    logic       zero_evt_o;

    always #4 clk = ~clk;

    cdt_top #(.CNT_W(8)) u0 (
        .clk(clk), .rst(rst), .tick_taps(tick_taps), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count_o(count_o),
        .zero_evt_o(zero_evt_o)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_cnt = 0, m_rld = 0, m_td = 0;
    bit m_en = 0, m_re = 0, m_def = 1, m_evt = 0;

    always @(posedge clk) begin
        int sel;
        bit tk;
        if (rst) begin
            m_cnt = 0; m_rld = 0; m_td = 0;
            m_en = 0; m_re = 0; m_def = 1; m_evt = 0;
        end else begin
            m_evt = 0;
            sel = m_def ? 4 : m_td;
            tk = tick_taps[sel];
            if (wr_en && wr_addr) begin
                m_cnt = wr_data; m_rld = wr_data;
            end else if (tk && m_en) begin
                if (m_cnt > 0) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_evt = 1;
                end else if (m_re) begin
                    m_cnt = m_rld;
                end
            end
            if (wr_en && !wr_addr) begin
                m_en = wr_data[0]; m_re = wr_data[1];
                if (wr_data[4]) begin
                    m_td = wr_data[3:2]; m_def = 0;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_model();
        check({cur_req, " count"}, count_o, m_cnt);
        check({cur_req, " zero_evt"}, zero_evt_o, m_evt);
    endtask

    task automatic step(input logic [4:0] t, input logic we, input logic a,
                        input logic [7:0] d);
        @(negedge clk);
        compare_model();
        tick_taps = t; wr_en = we; wr_addr = a; wr_data = d;
    endtask

    task automatic pulse(input logic [4:0] t);
        step(t, 0, 0, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        step(0, 1, a, d);
        step(0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, 0);
        // R1 reset state
        check("R1 count", count_o, 0);
        check("R1 zero_evt", zero_evt_o, 0);

        // R5 disabled timer ignores ticks
        cur_req = "R5";
        wr(1, 8'd3);
        pulse(5'b11111);
        check("R5 disabled hold", count_o, 3);

        // R2 enable without rate update keeps 32 Hz default (bit 4)
        cur_req = "R2";
        wr(0, 8'h01);
        pulse(5'b01111);
        check("R2 default ignores TD taps", count_o, 3);
        pulse(5'b10000);
        check("R2 default 32Hz tap", count_o, 2);

        // R4 load beats a same-cycle tick
        cur_req = "R4";
        step(5'b10000, 1, 1, 8'd9);
        step(0, 0, 0, 0);
        check("R4 load wins", count_o, 9);

        // R3 each TD picks its own tap
        cur_req = "R3";
        for (int td = 0; td < 4; td++) begin
            wr(0, 8'(8'h11 | (td << 2)));
            wr(1, 8'd4);
            pulse(5'(5'b11111 & ~(1 << td)));
            check("R3 other taps ignored", count_o, 4);
            pulse(5'(1 << td));
            check("R3 selected tap", count_o, 3);
            // R2 write without update bit keeps this TD
            wr(0, 8'h01);
            pulse(5'(1 << td));
            check("R2 rate kept", count_o, 2);
        end

        // R6 R7 R8 run to zero without reload (TD=2)
        cur_req = "R8";
        wr(0, 8'h19);
        wr(1, 8'd2);
        pulse(5'b00100);
        check("R6 step", count_o, 1);
        step(5'b00100, 0, 0, 0);
        step(0, 0, 0, 0);
        check("R7 zero reached", count_o, 0);
        check("R7 event high", zero_evt_o, 1);
        step(0, 0, 0, 0);
        check("R7 event one cycle", zero_evt_o, 0);
        pulse(5'b00100);
        pulse(5'b00100);
        check("R8 stays zero", count_o, 0);
        check("R8 no event", zero_evt_o, 0);

        // R9 auto-reload
        cur_req = "R9";
        wr(0, 8'h1B);
        wr(1, 8'd2);
        pulse(5'b00100);
        pulse(5'b00100);
        check("R9 at zero", count_o, 0);
        pulse(5'b00100);
        check("R9 reloaded", count_o, 2);
        for (int k = 0; k < 12; k++) pulse(5'b00100);

        // R10 writing zero gives no event, reload of zero stays
        cur_req = "R10";
        wr(1, 8'd0);
        check("R10 no event on load", zero_evt_o, 0);
        pulse(5'b00100);
        check("R10 reload zero", count_o, 0);

        // long run from full scale
        cur_req = "R6";
        wr(1, 8'd255);
        for (int k = 0; k < 256; k++) step(5'b00100, 0, 0, 0);
        step(0, 0, 0, 0);

        // randomized mix
        cur_req = "R3";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 4)
                step(5'($urandom), 1, 0, 8'($urandom));
            else if (r < 8)
                step(5'($urandom), 1, 1, 8'($urandom_range(0, 6)));
            else
                step(5'($urandom), 0, 0, 0);
        end
        step(0, 0, 0, 0);

        done = 1;
        finish_run();
    end

endmodule